// File: doc/BRIEF.md
# Dual Circular Line-Event Table Writer

This block collects per-line character events from the communication line modules and stores each one as a 32-bit entry in one of two circular tables held in a shared word memory. Each line module keeps only a single character. Software assembles whole messages later by reading the tables.

A high-speed output line that asks for its next character is sent to the fast table, which has 128 entries. Every other event goes to the bulk table, which has 256 entries. That covers requests from ordinary output lines and every received input character, including input on a high-speed line.

Events arrive on several valid/ready source ports and are arbitrated to one per cycle. The winning event is placed in a single holding register. The holding register then issues a memory write on a time-shared address/word bus and waits for a grant. Each table has a write pointer that wraps. Software consumes entries and moves the table's read pointer through a write strobe. A table is full when its write pointer plus one equals its read pointer. In that case the event that targets it is held back at its source port, not dropped, and the table's overflow flag is raised.

Top module: `chan_activity_writer`

## Requirements
- R1: After a synchronous active-high reset, `mem_req`, both overflow flags, all four pointers and all `src_ready` bits are 0.
- R2: An event with `src_fast`=1 and `src_input`=0 is written to the fast table, and the fast write pointer advances by one when it is accepted.
- R3: Every other event is written to the bulk table, and the bulk write pointer advances by one when it is accepted. This includes input events on fast lines.
- R4: The written word has the character in bits [7:0], the line identity in [14:8], the direction in bit 15 (1 = input) and the high-speed flag in bit 16. Bits [31:17] are zero.
- R5: The write address is the table's base address plus the write pointer value held at the moment the event was accepted.
- R6: Once `mem_req` is raised, it stays high with a stable address and word until the cycle in which `mem_gnt` is high. A new event can be accepted in that same grant cycle.
- R7: When events for both tables are valid in the same cycle, a fast-table event is accepted first. At most one `src_ready` is high per cycle.
- R8: An event whose table is full is not accepted. Its `src_ready` stays low, the write pointer holds, and the table's overflow flag is set on the next edge. Events for the other table are still accepted.
- R9: A software write to a table's read pointer loads that pointer and clears that table's overflow flag on the same edge.
- R10: Among events for the same table, the lowest-numbered source port is accepted first.
- R11: A write pointer at the last entry of its table wraps to 0 on its next advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | NUM_SRC | Event present on each source port |
| src_ready | output | NUM_SRC | Event accepted on each source port |
| src_fast | input | NUM_SRC | Originating line is high speed |
| src_input | input | NUM_SRC | 1 = received character, 0 = output request |
| src_line | input | NUM_SRC x 7 | Line identity per source |
| src_char | input | NUM_SRC x 8 | Character per source (input events) |
| rd1_we | input | 1 | Load the fast-table read pointer |
| rd1_val | input | 7 | New fast-table read pointer |
| rd2_we | input | 1 | Load the bulk-table read pointer |
| rd2_val | input | 8 | New bulk-table read pointer |
| mem_req | output | 1 | Memory write request |
| mem_gnt | input | 1 | Bus grant; completes the pending write |
| mem_addr | output | ADDR_W | Write word address |
| mem_wdata | output | 32 | Entry word being written |
| wr_ptr1 | output | 7 | Fast-table write pointer |
| wr_ptr2 | output | 8 | Bulk-table write pointer |
| rd_ptr1 | output | 7 | Fast-table read pointer |
| rd_ptr2 | output | 8 | Bulk-table read pointer |
| ovf1 | output | 1 | Fast table overflowed (sticky) |
| ovf2 | output | 1 | Bulk table overflowed (sticky) |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the completion of a granted bus write and the acceptance of the next event. The bench holds `mem_gnt` high across back-to-back events and also withholds it for several cycles. In both cases it expects acceptance exactly in the grant cycle.

The second pair is a table stall and progress on the other table. The bench fills the fast table until it stalls, then offers a bulk event and expects that event to pass while the overflow flag stays set. It then loads the read pointer in a cycle where the stalled event is still valid, and expects the flag to clear while the event waits one more edge.

A behavioural model with integer pointers predicts every port on every cycle.

// File: rtl/cat_pkg.sv
package cat_pkg;
    localparam int LINE_W = 7;
    localparam int CHAR_W = 8;
    localparam int WORD_W = 32;
    localparam int PAD_W  = WORD_W - CHAR_W - LINE_W - 2;

    typedef enum logic {
        TBL_FAST = 1'b0,
        TBL_BULK = 1'b1
    } tbl_e;

    typedef struct packed {
        logic [PAD_W-1:0]  pad;
        logic              hs;
        logic              dir_in;
        logic [LINE_W-1:0] line;
        logic [CHAR_W-1:0] ch;
    } entry_t;

    function automatic tbl_e route(input logic hs, input logic dir_in);
        return (hs && !dir_in) ? TBL_FAST : TBL_BULK;
    endfunction

    function automatic entry_t make_entry(input logic hs, input logic dir_in,
                                          input logic [LINE_W-1:0] line,
                                          input logic [CHAR_W-1:0] ch);
        entry_t e;
        e.pad    = '0;
        e.hs     = hs;
        e.dir_in = dir_in;
        e.line   = line;
        e.ch     = ch;
        return e;
    endfunction
endpackage

// File: rtl/cat_arbiter.sv
module cat_arbiter
    import cat_pkg::*;
#(
    parameter int NUM_SRC = 2,
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] valid,
    input  logic [NUM_SRC-1:0] fast,
    input  logic [NUM_SRC-1:0] dir_in,
    input  logic               full_fast,
    input  logic               full_bulk,
    input  logic               free,
    output logic [NUM_SRC-1:0] grant,
    output logic [IDX_W-1:0]   win_idx,
    output logic               win_fast,
    output logic               stall_fast,
    output logic               stall_bulk
);
    logic [NUM_SRC-1:0] want_fast, want_bulk;
    logic [NUM_SRC-1:0] cand_fast, cand_bulk;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_route
        tbl_e t;
        assign t            = route(fast[i], dir_in[i]);
        assign want_fast[i] = valid[i] && (t == TBL_FAST);
        assign want_bulk[i] = valid[i] && (t == TBL_BULK);
    end

    assign cand_fast  = full_fast ? '0 : want_fast;
    assign cand_bulk  = full_bulk ? '0 : want_bulk;
    assign stall_fast = full_fast && (|want_fast);
    assign stall_bulk = full_bulk && (|want_bulk);

    always_comb begin
        logic [NUM_SRC-1:0] pool;
        logic               any;
        grant    = '0;
        win_idx  = '0;
        win_fast = |cand_fast;
        pool     = win_fast ? cand_fast : cand_bulk;
        any      = |pool;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pool[i]) win_idx = IDX_W'(i);
        end
        if (any && free) grant[win_idx] = 1'b1;
    end

    // R7
    one_winner_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R8
    full_fast_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        full_fast |-> (grant & want_fast) == '0);

    // R8
    full_bulk_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        full_bulk |-> (grant & want_bulk) == '0);
endmodule

// File: rtl/cat_ring.sv
module cat_ring #(
    parameter int DEPTH = 128,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          stall,
    input  logic          rd_we,
    input  logic [PW-1:0] rd_val,
    output logic [PW-1:0] wr,
    output logic [PW-1:0] rd,
    output logic          full,
    output logic          ovf
);
    logic [PW-1:0] wr_next;

    assign wr_next = wr + 1'b1;
    assign full    = (wr_next == rd);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr  <= '0;
            rd  <= '0;
            ovf <= 1'b0;
        end else begin
            if (adv) wr <= wr_next;
            if (rd_we) rd <= rd_val;
            if (rd_we) ovf <= 1'b0;
            else if (stall) ovf <= 1'b1;
        end
    end

    // R8
    no_adv_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !adv);

    // R9
    ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rd_we |=> !ovf);

    // R11
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && wr == PW'(DEPTH - 1)) |=> wr == '0);
endmodule

// File: rtl/cat_bus_port.sv
module cat_bus_port #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              gnt,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              free
);
    assign free = !req || gnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            req  <= 1'b0;
            addr <= '0;
            data <= '0;
        end else if (load) begin
            req  <= 1'b1;
            addr <= load_addr;
            data <= load_data;
        end else if (gnt) begin
            req <= 1'b0;
        end
    end

    // R6
    hold_until_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !gnt) |=> (req && $stable(addr) && $stable(data)));

    // R6
    load_only_when_free_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> (!req || gnt));
endmodule

// File: rtl/chan_activity_writer.sv
module chan_activity_writer
    import cat_pkg::*;
#(
    parameter int NUM_SRC  = 2,
    parameter int ADDR_W   = 16,
    parameter int T1_DEPTH = 128,
    parameter int T2_DEPTH = 256,
    parameter logic [ADDR_W-1:0] T1_BASE = 16'h0100,
    parameter logic [ADDR_W-1:0] T2_BASE = 16'h0400,
    localparam int T1_PW = $clog2(T1_DEPTH),
    localparam int T2_PW = $clog2(T2_DEPTH),
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_SRC-1:0]              src_valid,
    output logic [NUM_SRC-1:0]              src_ready,
    input  logic [NUM_SRC-1:0]              src_fast,
    input  logic [NUM_SRC-1:0]              src_input,
    input  logic [NUM_SRC-1:0][LINE_W-1:0]  src_line,
    input  logic [NUM_SRC-1:0][CHAR_W-1:0]  src_char,
    input  logic                            rd1_we,
    input  logic [T1_PW-1:0]                rd1_val,
    input  logic                            rd2_we,
    input  logic [T2_PW-1:0]                rd2_val,
    output logic                            mem_req,
    input  logic                            mem_gnt,
    output logic [ADDR_W-1:0]               mem_addr,
    output logic [WORD_W-1:0]               mem_wdata,
    output logic [T1_PW-1:0]                wr_ptr1,
    output logic [T2_PW-1:0]                wr_ptr2,
    output logic [T1_PW-1:0]                rd_ptr1,
    output logic [T2_PW-1:0]                rd_ptr2,
    output logic                            ovf1,
    output logic                            ovf2
);
    logic             full1, full2, stall1, stall2;
    logic             free, win_fast, load;
    logic [IDX_W-1:0] win_idx;
    entry_t           entry;
    logic [ADDR_W-1:0] load_addr;

    cat_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk(clk), .rst(rst),
        .valid(src_valid), .fast(src_fast), .dir_in(src_input),
        .full_fast(full1), .full_bulk(full2), .free(free),
        .grant(src_ready), .win_idx(win_idx), .win_fast(win_fast),
        .stall_fast(stall1), .stall_bulk(stall2)
    );

    assign load = |src_ready;

    cat_ring #(.DEPTH(T1_DEPTH)) u_ring_fast (
        .clk(clk), .rst(rst),
        .adv(load && win_fast), .stall(stall1),
        .rd_we(rd1_we), .rd_val(rd1_val),
        .wr(wr_ptr1), .rd(rd_ptr1), .full(full1), .ovf(ovf1)
    );

    cat_ring #(.DEPTH(T2_DEPTH)) u_ring_bulk (
        .clk(clk), .rst(rst),
        .adv(load && !win_fast), .stall(stall2),
        .rd_we(rd2_we), .rd_val(rd2_val),
        .wr(wr_ptr2), .rd(rd_ptr2), .full(full2), .ovf(ovf2)
    );

    assign entry = make_entry(src_fast[win_idx], src_input[win_idx],
                              src_line[win_idx], src_char[win_idx]);
    assign load_addr = win_fast ? (T1_BASE + ADDR_W'(wr_ptr1))
                                : (T2_BASE + ADDR_W'(wr_ptr2));

    cat_bus_port #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_bus (
        .clk(clk), .rst(rst),
        .load(load), .load_addr(load_addr), .load_data(entry),
        .gnt(mem_gnt), .req(mem_req), .addr(mem_addr), .data(mem_wdata),
        .free(free)
    );

    logic in_t1, in_t2;
    assign in_t1 = (mem_addr - T1_BASE) < ADDR_W'(T1_DEPTH);
    assign in_t2 = (mem_addr - T2_BASE) < ADDR_W'(T2_DEPTH);

    // R5
    addr_in_table_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (in_t1 || in_t2));

    // R4
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_wdata[WORD_W-1:17] == '0);
endmodule

// File: tb/chan_activity_writer_tb.sv
module chan_activity_writer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int T1D = 128;
    localparam int T2D = 256;
    localparam int B1 = 'h0100;
    localparam int B2 = 'h0400;
    localparam int WATCHDOG = 150000;

    logic clk = 0, rst = 1;
    logic [1:0] sv = 0, sf = 0, si = 0;
    logic [1:0] srdy;
    logic [1:0][6:0] sl = '0;
    logic [1:0][7:0] sc = '0;
    logic rd1_we = 0, rd2_we = 0;
    logic [6:0] rd1_val = 0;
    logic [7:0] rd2_val = 0;
    logic mem_req, mem_gnt = 0;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [6:0] wr_ptr1, rd_ptr1;
    logic [7:0] wr_ptr2, rd_ptr2;
    logic ovf1, ovf2;

    chan_activity_writer u_dut (
        .clk(clk), .rst(rst), .src_valid(sv), .src_ready(srdy),
        .src_fast(sf), .src_input(si), .src_line(sl), .src_char(sc),
        .rd1_we(rd1_we), .rd1_val(rd1_val), .rd2_we(rd2_we), .rd2_val(rd2_val),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .wr_ptr1(wr_ptr1), .wr_ptr2(wr_ptr2),
        .rd_ptr1(rd_ptr1), .rd_ptr2(rd_ptr2), .ovf1(ovf1), .ovf2(ovf2)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0, errors = 0, cycles = 0;

    // model state
    int m_busy = 0, m_addr = 0, m_wr1 = 0, m_wr2 = 0, m_rd1 = 0, m_rd2 = 0;
    int m_ovf1 = 0, m_ovf2 = 0;
    longint m_data = 0;
    bit acc [2];

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++; errors++;
            $display("FAIL R6 watchdog act=%0d exp<%0d", cycles, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic step();
        int pick, nb, na, nw1, nw2, no1, no2;
        bit pick_t1, full1, full2, st1, st2, free;
        longint nd;
        logic [1:0] exp_rdy;
        #1;
        pick = -1; pick_t1 = 0; exp_rdy = 0;
        nb = m_busy; na = m_addr; nd = m_data; nw1 = m_wr1; nw2 = m_wr2;
        no1 = m_ovf1; no2 = m_ovf2;
        if (!rst) begin
            full1 = ((m_wr1 + 1) % T1D) == m_rd1;
            full2 = ((m_wr2 + 1) % T2D) == m_rd2;
            free = !m_busy || mem_gnt;
            st1 = 0; st2 = 0;
            for (int i = 0; i < 2; i++) begin
                if (sv[i] && sf[i] && !si[i] && full1) st1 = 1;
                if (sv[i] && !(sf[i] && !si[i]) && full2) st2 = 1;
            end
            for (int i = 0; i < 2; i++)
                if (pick < 0 && sv[i] && sf[i] && !si[i] && !full1) begin pick = i; pick_t1 = 1; end
            for (int i = 0; i < 2; i++)
                if (pick < 0 && sv[i] && !(sf[i] && !si[i]) && !full2) pick = i;
            if (!free) pick = -1;
            if (pick >= 0) exp_rdy[pick] = 1'b1;

            chk(mem_req === (m_busy != 0), "R6 mem_req", longint'(mem_req), longint'(m_busy));
            if (m_busy != 0) begin
                chk(int'(mem_addr) == m_addr, "R5 mem_addr", longint'(mem_addr), longint'(m_addr));
                chk(longint'(mem_wdata) == m_data, "R4 mem_wdata", longint'(mem_wdata), m_data);
            end
            chk(srdy === exp_rdy, "R7 R10 R8 src_ready", longint'(srdy), longint'(exp_rdy));
            chk(int'(wr_ptr1) == m_wr1, "R2 R11 wr_ptr1", longint'(wr_ptr1), longint'(m_wr1));
            chk(int'(wr_ptr2) == m_wr2, "R3 R11 wr_ptr2", longint'(wr_ptr2), longint'(m_wr2));
            chk(int'(rd_ptr1) == m_rd1 && int'(rd_ptr2) == m_rd2, "R9 rd_ptr",
                longint'({rd_ptr1, rd_ptr2}), longint'((m_rd1 << 8) | m_rd2));
            chk(int'(ovf1) == m_ovf1 && int'(ovf2) == m_ovf2, "R8 R9 ovf",
                longint'({ovf1, ovf2}), longint'((m_ovf1 << 1) | m_ovf2));

            if (m_busy != 0 && mem_gnt) nb = 0;
            if (pick >= 0) begin
                nb = 1;
                na = pick_t1 ? B1 + m_wr1 : B2 + m_wr2;
                nd = longint'(sc[pick]) | (longint'(sl[pick]) << 8) |
                     (longint'(si[pick]) << 15) | (longint'(sf[pick]) << 16);
                if (pick_t1) nw1 = (m_wr1 + 1) % T1D;
                else nw2 = (m_wr2 + 1) % T2D;
            end
            if (rd1_we) no1 = 0; else if (st1) no1 = 1;
            if (rd2_we) no2 = 0; else if (st2) no2 = 1;
        end
        @(posedge clk);
        if (rst) begin
            m_busy = 0; m_addr = 0; m_data = 0; m_wr1 = 0; m_wr2 = 0;
            m_rd1 = 0; m_rd2 = 0; m_ovf1 = 0; m_ovf2 = 0;
        end else begin
            m_busy = nb; m_addr = na; m_data = nd; m_wr1 = nw1; m_wr2 = nw2;
            m_ovf1 = no1; m_ovf2 = no2;
            if (rd1_we) m_rd1 = int'(rd1_val);
            if (rd2_we) m_rd2 = int'(rd2_val);
        end
        for (int i = 0; i < 2; i++) acc[i] = exp_rdy[i];
        @(negedge clk);
        for (int i = 0; i < 2; i++) if (acc[i]) sv[i] = 1'b0;
    endtask

    task automatic offer(input int p, input bit f, input bit inp, input int line, input int ch);
        sv[p] = 1'b1; sf[p] = f; si[p] = inp; sl[p] = 7'(line); sc[p] = 8'(ch);
    endtask

    task automatic drain();
        for (int k = 0; k < 40 && (sv != 0 || m_busy != 0); k++) step();
    endtask

    initial begin
        @(negedge clk);
        step(); step();
        rst = 0;
        #1;
        // R1 reset state
        chk(mem_req === 1'b0 && srdy === 2'b00, "R1 req/ready after reset",
            longint'({mem_req, srdy}), 0);
        chk(wr_ptr1 == 0 && wr_ptr2 == 0 && rd_ptr1 == 0 && rd_ptr2 == 0,
            "R1 pointers after reset", longint'({wr_ptr1, wr_ptr2, rd_ptr1, rd_ptr2}), 0);
        chk(ovf1 === 1'b0 && ovf2 === 1'b0, "R1 overflow after reset",
            longint'({ovf1, ovf2}), 0);
        @(negedge clk);

        mem_gnt = 1;
        // R2: fast output request
        offer(0, 1, 0, 5, 0); drain();
        // R3 R10: fast input and slow input both bulk, port 0 first
        offer(0, 1, 1, 9, 'h3C); offer(1, 0, 1, 'h7F, 'hA5); drain();
        // R7: bulk on port 0, fast on port 1 -> port 1 first
        offer(0, 0, 0, 17, 0); offer(1, 1, 0, 33, 'h11); drain();
        // R6: grant withheld several cycles
        mem_gnt = 0;
        offer(1, 0, 1, 44, 'h5A); offer(0, 1, 0, 2, 'h77);
        for (int k = 0; k < 5; k++) step();
        mem_gnt = 1; drain();

        // R8 R11: fill fast table until stall, bulk still flows
        for (int k = 0; k < 140; k++) begin
            if (!sv[0]) offer(0, 1, 0, k, k);
            if (k == 132) offer(1, 0, 1, 3, 'hC3);
            step();
        end
        chk(ovf1 === 1'b1, "R8 ovf1 set while stalled", longint'(ovf1), 1);
        // R9: read pointer write clears flag while event still pending
        rd1_val = 7'd64; rd1_we = 1; step(); rd1_we = 0;
        chk(ovf1 === 1'b0, "R9 ovf1 cleared", longint'(ovf1), 0);
        for (int k = 0; k < 80; k++) begin
            if (!sv[0]) offer(0, 1, 0, k, k + 1);
            step();
        end
        sv[0] = 0; drain();
        rd1_val = 7'(m_wr1); rd1_we = 1; step(); rd1_we = 0;

        // R3 R8 R11: fill bulk table
        for (int k = 0; k < 270; k++) begin
            if (!sv[1]) offer(1, 0, 1, k, k ^ 'h55);
            step();
        end
        chk(ovf2 === 1'b1, "R8 ovf2 set while stalled", longint'(ovf2), 1);
        rd2_val = 8'd200; rd2_we = 1; step(); rd2_we = 0;
        chk(ovf2 === 1'b0, "R9 ovf2 cleared", longint'(ovf2), 0);
        for (int k = 0; k < 20; k++) step();
        sv = 0; drain();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule